// File: doc/BRIEF.md
# Nibble-coded 8-bit multicycle core

This block is a small processor core that runs programs held in its own 256-byte memory. That memory holds both code and data. The core has sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. Every instruction is two bytes long. The top nibble is the opcode and the three lower nibbles are operands. When an 8-bit address or constant is needed, the low byte of the instruction supplies it. A fetch takes two cycles, one byte per cycle, and is followed by one execute cycle.

A host fills the memory through the image-load port while the core is idle. It then starts the core in one of two modes. `run` executes instructions until a halt or until an instruction cap is reached. `step` executes exactly one instruction. A register select input and a memory peek, addressed by the load address, let the host read back state at any time.

Top module: `nib8_core`

## Requirements
- R1: An instruction is fetched from two memory cells: the byte at `pc` is the high byte and the byte at `pc+1` is the low byte. The fetch takes two cycles and execution takes one more, so `busy` is high for exactly three cycles per instruction. Opcode is bits 15:12; nibble fields N1 = bits 11:8, N2 = bits 7:4, N3 = bits 3:0; byte field K = bits 7:0.
- R2: Opcode 1 writes mem[K] into register N1. Opcode 2 writes K into register N1. Opcode 3 writes register N1 into mem[K]. Opcode 4 copies register N2 into register N3.
- R3: Opcodes 5 and 6 both write the low 8 bits of register N2 plus register N3 into register N1.
- R4: Opcodes 7, 8 and 9 write the bitwise OR, AND and XOR of registers N2 and N3 into register N1.
- R5: Opcode A rotates register N1 right by N3 modulo 8 places. Bits leaving bit 0 re-enter at bit 7.
- R6: Opcode B loads `pc` with K when register N1 equals register 0, bit for bit. Otherwise execution continues with the next instruction.
- R7: Opcode C sets `halted` and returns the core to idle. While `halted` is set, `run` and `step` are ignored.
- R8: While idle, `ld_en` writes `ld_data` to mem[`ld_addr`] and clears `pc`, `ir`, `halted` and `limit_hit`. Registers keep their values.
- R9: `pc` rises by 2 for each instruction that does not jump, and wraps modulo 256.
- R10: In run mode the core returns to idle with `limit_hit` set after MAX_INSNS executed instructions, counted from the start of the run. The default cap is 10000.
- R11: A `step` pulse executes one instruction and returns to idle. Starting either mode clears `limit_hit`.
- R12: Opcodes 0, D, E and F change nothing except advancing `pc`.
- R13: After reset, `pc`, `ir`, all registers and all memory cells are zero, and `busy`, `halted` and `limit_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one image byte (idle only) |
| ld_addr | input | 8 | Image byte address; also the memory peek address |
| ld_data | input | 8 | Image byte value |
| run | input | 1 | Start free-running execution |
| step | input | 1 | Execute one instruction |
| reg_sel | input | 4 | Register read-back select |
| reg_data | output | 8 | Value of the selected register |
| mem_data | output | 8 | Memory cell at `ld_addr` |
| pc | output | 8 | Program counter |
| ir | output | 16 | Instruction register |
| busy | output | 1 | Core is fetching or executing |
| halted | output | 1 | A halt instruction has executed |
| limit_hit | output | 1 | The last run stopped at the instruction cap |

## Verification
A mixed program exercises every opcode with operands chosen so that each result is distinct: 0x7F and 0x05 give different outputs under add, OR, AND and XOR. A rotate count of 9 is included to separate modulo-8 handling from a raw shift. Jumps are tried both ways. A not-taken compare against a nonzero register checks the comparison with register 0. A taken jump skips over a register write, and a branch near the top of memory shows the `pc` wrap. Step mode checks the three-cycle timing and confirms that halt blocks further starts. A self-loop program reaches the instruction cap, which separates a cap stop from a halt stop.

// File: rtl/nib8_pkg.sv
// Package: shared opcode values, controller phases and the execute result
// record for the nibble-coded core. Assumes a 16-bit instruction whose top
// nibble is the opcode.
package nib8_pkg;

    localparam int IR_W = 16;

    localparam logic [3:0] OP_LOAD  = 4'h1;
    localparam logic [3:0] OP_SET   = 4'h2;
    localparam logic [3:0] OP_STORE = 4'h3;
    localparam logic [3:0] OP_MOVE  = 4'h4;
    localparam logic [3:0] OP_ADDB  = 4'h5;
    localparam logic [3:0] OP_ADDF  = 4'h6;
    localparam logic [3:0] OP_OR    = 4'h7;
    localparam logic [3:0] OP_AND   = 4'h8;
    localparam logic [3:0] OP_XOR   = 4'h9;
    localparam logic [3:0] OP_ROT   = 4'hA;
    localparam logic [3:0] OP_JEQ   = 4'hB;
    localparam logic [3:0] OP_HALT  = 4'hC;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH_HI = 2'd1,
        ST_FETCH_LO = 2'd2,
        ST_EXEC     = 2'd3
    } phase_e;

    typedef struct packed {
        logic       reg_we;
        logic [3:0] reg_addr;
        logic [7:0] reg_wdata;
        logic       mem_we;
        logic       jump;
        logic       halt;
    } exec_res_t;

endpackage

// File: rtl/nib8_mem.sv
// Module: unified program/data memory, 2**AW cells of DW bits.
// Two write ports: image load and store instruction. The controller never
// enables both in one cycle; image load wins if it did. Three combinational
// read ports: fetch, data operand and host peek. Reset clears every cell.
module nib8_mem #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_wdata,
    input  logic          st_we,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_wdata,
    input  logic [AW-1:0] fetch_addr,
    output logic [DW-1:0] fetch_rdata,
    output logic [DW-1:0] data_rdata,
    output logic [DW-1:0] peek_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Cell update: reset clear, then image load, then store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (ld_we) begin
            cells[ld_addr] <= ld_wdata;
        end else if (st_we) begin
            cells[st_addr] <= st_wdata;
        end
    end

    // Read ports: asynchronous lookups.
    always_comb begin
        fetch_rdata = cells[fetch_addr];
        data_rdata  = cells[st_addr];
        peek_rdata  = cells[ld_addr];
    end
endmodule

// File: rtl/nib8_regfile.sv
// Module: general register file, NREG entries of DW bits.
// Three operand read ports, a read-back port and a register-0 tap; one
// write port. Writes land at the clock edge that ends the execute cycle.
module nib8_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [$clog2(NREG)-1:0] ra_addr,
    output logic [DW-1:0]           ra_data,
    input  logic [$clog2(NREG)-1:0] rb_addr,
    output logic [DW-1:0]           rb_data,
    input  logic [$clog2(NREG)-1:0] rc_addr,
    output logic [DW-1:0]           rc_data,
    input  logic [$clog2(NREG)-1:0] dbg_addr,
    output logic [DW-1:0]           dbg_data,
    output logic [DW-1:0]           r0_data
);
    logic [DW-1:0] regs [NREG];

    // Register update: reset clear, single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports.
    always_comb begin
        ra_data  = regs[ra_addr];
        rb_data  = regs[rb_addr];
        rc_data  = regs[rc_addr];
        dbg_data = regs[dbg_addr];
        r0_data  = regs[0];
    end
endmodule

// File: rtl/nib8_alu.sv
// Module: decode and execute datapath for one instruction.
// Purely combinational; the controller qualifies its outputs with the execute
// phase. Assumes DW = 8 (byte field equals a data word, 4-bit nibbles).
module nib8_alu
    import nib8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [IR_W-1:0] ir,
    input  logic [DW-1:0]   n1_val,
    input  logic [DW-1:0]   n2_val,
    input  logic [DW-1:0]   n3_val,
    input  logic [DW-1:0]   r0_val,
    input  logic [DW-1:0]   mem_val,
    output exec_res_t       res
);
    localparam int SHW = $clog2(DW);

    logic [3:0]      op;
    logic [3:0]      n1;
    logic [3:0]      n3;
    logic [DW-1:0]   kbyte;
    logic [2*DW-1:0] rot_dbl;

    // Field split and rotate helper.
    always_comb begin
        op      = ir[15:12];
        n1      = ir[11:8];
        n3      = ir[3:0];
        kbyte   = ir[DW-1:0];
        rot_dbl = {n1_val, n1_val} >> n3[SHW-1:0];
    end

    // Per-opcode result selection.
    always_comb begin
        res           = '0;
        res.reg_addr  = n1;
        unique case (op)
            OP_LOAD:  begin res.reg_we = 1'b1; res.reg_wdata = mem_val; end
            OP_SET:   begin res.reg_we = 1'b1; res.reg_wdata = kbyte; end
            OP_STORE: res.mem_we = 1'b1;
            OP_MOVE:  begin
                res.reg_we    = 1'b1;
                res.reg_addr  = n3;
                res.reg_wdata = n2_val;
            end
            OP_ADDB, OP_ADDF: begin
                res.reg_we    = 1'b1;
                res.reg_wdata = n2_val + n3_val;
            end
            OP_OR:    begin res.reg_we = 1'b1; res.reg_wdata = n2_val | n3_val; end
            OP_AND:   begin res.reg_we = 1'b1; res.reg_wdata = n2_val & n3_val; end
            OP_XOR:   begin res.reg_we = 1'b1; res.reg_wdata = n2_val ^ n3_val; end
            OP_ROT:   begin res.reg_we = 1'b1; res.reg_wdata = rot_dbl[DW-1:0]; end
            OP_JEQ:   res.jump = (n1_val == r0_val);
            OP_HALT:  res.halt = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/nib8_core.sv
// Module: top of the nibble-coded 8-bit core. Holds the phase controller,
// program counter, instruction register and run/step bookkeeping, and wires
// memory, register file and execute datapath. Image load is accepted only
// while idle. MAX_INSNS caps one free run.
module nib8_core
    import nib8_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 8,
    parameter int NREG      = 16,
    parameter int MAX_INSNS = 10000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_en,
    input  logic [AW-1:0]           ld_addr,
    input  logic [DW-1:0]           ld_data,
    input  logic                    run,
    input  logic                    step,
    input  logic [$clog2(NREG)-1:0] reg_sel,
    output logic [DW-1:0]           reg_data,
    output logic [DW-1:0]           mem_data,
    output logic [AW-1:0]           pc,
    output logic [IR_W-1:0]         ir,
    output logic                    busy,
    output logic                    halted,
    output logic                    limit_hit
);
    localparam int CNT_W = $clog2(MAX_INSNS + 1);
    localparam int RAW   = $clog2(NREG);

    phase_e         st;
    logic           free_run;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    exec_res_t      res;
    logic [DW-1:0]  fetch_rdata;
    logic [DW-1:0]  data_rdata;
    logic [DW-1:0]  n1_val;
    logic [DW-1:0]  n2_val;
    logic [DW-1:0]  n3_val;
    logic [DW-1:0]  r0_val;
    logic           in_exec;
    logic           load_now;

    // Phase qualifiers.
    always_comb begin
        in_exec  = (st == ST_EXEC);
        load_now = (st == ST_IDLE) && ld_en;
        busy     = (st != ST_IDLE);
        cnt_next = cnt + 1'b1;
    end

    nib8_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (load_now),
        .ld_addr    (ld_addr),
        .ld_wdata   (ld_data),
        .st_we      (in_exec && res.mem_we),
        .st_addr    (ir[AW-1:0]),
        .st_wdata   (n1_val),
        .fetch_addr (pc),
        .fetch_rdata(fetch_rdata),
        .data_rdata (data_rdata),
        .peek_rdata (mem_data)
    );

    nib8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (in_exec && res.reg_we),
        .waddr   (res.reg_addr[RAW-1:0]),
        .wdata   (res.reg_wdata),
        .ra_addr (ir[11:8]),
        .ra_data (n1_val),
        .rb_addr (ir[7:4]),
        .rb_data (n2_val),
        .rc_addr (ir[3:0]),
        .rc_data (n3_val),
        .dbg_addr(reg_sel),
        .dbg_data(reg_data),
        .r0_data (r0_val)
    );

    nib8_alu #(.DW(DW)) u_alu (
        .ir     (ir),
        .n1_val (n1_val),
        .n2_val (n2_val),
        .n3_val (n3_val),
        .r0_val (r0_val),
        .mem_val(data_rdata),
        .res    (res)
    );

    // Controller: image load, start, two fetch phases, execute and stop rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            pc        <= '0;
            ir        <= '0;
            halted    <= 1'b0;
            limit_hit <= 1'b0;
            free_run  <= 1'b0;
            cnt       <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (ld_en) begin
                        pc        <= '0;
                        ir        <= '0;
                        halted    <= 1'b0;
                        limit_hit <= 1'b0;
                    end else if ((run || step) && !halted) begin
                        free_run  <= run;
                        cnt       <= '0;
                        limit_hit <= 1'b0;
                        st        <= ST_FETCH_HI;
                    end
                end
                ST_FETCH_HI: begin
                    ir[15:8] <= fetch_rdata;
                    pc       <= pc + 1'b1;
                    st       <= ST_FETCH_LO;
                end
                ST_FETCH_LO: begin
                    ir[7:0] <= fetch_rdata;
                    pc      <= pc + 1'b1;
                    st      <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (res.halt) begin
                        halted <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        if (res.jump) pc <= ir[AW-1:0];
                        cnt <= cnt_next;
                        if (free_run && (cnt_next < CNT_W'(MAX_INSNS))) begin
                            st <= ST_FETCH_HI;
                        end else begin
                            st        <= ST_IDLE;
                            limit_hit <= free_run;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nib8_core_chk.sv
// Module: property checker for nib8_core, attached by bind. Observes the
// controller phase, counters and operand taps; drives nothing.
module nib8_core_chk
    import nib8_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 8,
    parameter int CNT_W     = 14,
    parameter int MAX_INSNS = 10000
) (
    input logic             clk,
    input logic             rst_n,
    input phase_e           st,
    input logic [AW-1:0]    pc,
    input logic [IR_W-1:0]  ir,
    input logic             halted,
    input logic             limit_hit,
    input logic             ld_en,
    input logic             free_run,
    input logic [CNT_W-1:0] cnt,
    input logic [DW-1:0]    n1_val,
    input logic [DW-1:0]    r0_val
);
    AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH_HI || st == ST_FETCH_LO) |=> pc == $past(pc) + 1'b1); // R9

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && halted && !ld_en) |=> (halted && st == ST_IDLE)); // R7

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ld_en) |=> (pc == '0 && ir == '0 && !halted && !limit_hit)); // R8

    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXEC && ir[15:12] == OP_JEQ && n1_val == r0_val)
            |=> pc == $past(ir[AW-1:0])); // R6

    AST_JUMP_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXEC && ir[15:12] == OP_JEQ && n1_val != r0_val)
            |=> pc == $past(pc)); // R6

    AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_INSNS)); // R10

    AST_LIMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        limit_hit |-> st == ST_IDLE); // R10

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXEC && !free_run) |=> st == ST_IDLE); // R11
endmodule

bind nib8_core nib8_core_chk #(
    .DW(DW), .AW(AW), .CNT_W(CNT_W), .MAX_INSNS(MAX_INSNS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .pc       (pc),
    .ir       (ir),
    .halted   (halted),
    .limit_hit(limit_hit),
    .ld_en    (ld_en),
    .free_run (free_run),
    .cnt      (cnt),
    .n1_val   (n1_val),
    .r0_val   (r0_val)
);

// File: tb/nib8_core_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated at every rising edge and
// compared with the core at every falling edge, plus hand-computed checks.
module nib8_core_tb;
    localparam int MAXI = 10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        run = 1'b0;
    logic        step = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [7:0]  reg_data, mem_data, pc;
    logic [15:0] ir;
    logic        busy, halted, limit_hit;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit cmp_en  = 1'b0;

    // reference model state
    logic [7:0]  m_mem [256];
    logic [7:0]  m_r   [16];
    logic [7:0]  m_pc;
    logic [15:0] m_ir;
    int          m_ph;
    bit          m_halt, m_lim, m_free;
    int          m_cnt;
    logic [7:0]  img   [256];

    always #2 clk = ~clk;

    nib8_core u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .run(run), .step(step), .reg_sel(reg_sel),
        .reg_data(reg_data), .mem_data(mem_data), .pc(pc), .ir(ir),
        .busy(busy), .halted(halted), .limit_hit(limit_hit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model: one update per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = '0;
            foreach (m_r[i]) m_r[i] = '0;
            m_pc = '0; m_ir = '0; m_ph = 0;
            m_halt = 0; m_lim = 0; m_free = 0; m_cnt = 0;
        end else begin
            case (m_ph)
                0: begin
                    if (ld_en) begin
                        m_mem[ld_addr] = ld_data;
                        m_pc = '0; m_ir = '0; m_halt = 0; m_lim = 0;
                    end else if ((run || step) && !m_halt) begin
                        m_free = run; m_cnt = 0; m_lim = 0; m_ph = 1;
                    end
                end
                1: begin m_ir[15:8] = m_mem[m_pc]; m_pc = m_pc + 1; m_ph = 2; end
                2: begin m_ir[7:0]  = m_mem[m_pc]; m_pc = m_pc + 1; m_ph = 3; end
                default: begin
                    automatic logic [3:0] a = m_ir[11:8];
                    automatic logic [3:0] b = m_ir[7:4];
                    automatic logic [3:0] c = m_ir[3:0];
                    automatic logic [7:0] k = m_ir[7:0];
                    automatic logic [15:0] w;
                    if (m_ir[15:12] == 4'hC) begin
                        m_halt = 1; m_ph = 0;
                    end else begin
                        case (m_ir[15:12])
                            4'h1: m_r[a] = m_mem[k];
                            4'h2: m_r[a] = k;
                            4'h3: m_mem[k] = m_r[a];
                            4'h4: m_r[c] = m_r[b];
                            4'h5, 4'h6: m_r[a] = m_r[b] + m_r[c];
                            4'h7: m_r[a] = m_r[b] | m_r[c];
                            4'h8: m_r[a] = m_r[b] & m_r[c];
                            4'h9: m_r[a] = m_r[b] ^ m_r[c];
                            4'hA: begin
                                w = {m_r[a], m_r[a]} >> (c % 8);
                                m_r[a] = w[7:0];
                            end
                            4'hB: if (m_r[a] == m_r[0]) m_pc = k;
                            default: ;
                        endcase
                        m_cnt++;
                        if (m_free && m_cnt < MAXI) m_ph = 1;
                        else begin m_ph = 0; if (m_free) m_lim = 1; end
                    end
                end
            endcase
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk("R9 pc", pc, m_pc);
            chk("R1 ir", ir, m_ir);
            chk("R7 halted", halted, m_halt);
            chk("R10 limit_hit", limit_hit, m_lim);
            chk("R11 busy", busy, m_ph != 0);
            chk("R2 reg_data", reg_data, m_r[reg_sel]);
            chk("R2 mem_data", mem_data, m_mem[ld_addr]);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        reg_sel = reg_sel + 1'b1;
    endtask

    task automatic clear_img();
        foreach (img[i]) img[i] = 8'h00;
    endtask

    task automatic put(input int addr, input logic [15:0] word);
        img[addr[7:0]]         = word[15:8];
        img[(addr + 1) % 256]  = word[7:0];
    endtask

    task automatic load_img();
        ld_en = 1'b1;
        for (int a = 0; a < 256; a++) begin
            ld_addr = a[7:0];
            ld_data = img[a];
            tick();
        end
        ld_en = 1'b0;
    endtask

    task automatic run_prog();
        run = 1'b1; tick(); run = 1'b0;
        while (busy) tick();
    endtask

    task automatic step_one(output int n);
        n = 0;
        step = 1'b1; tick(); step = 1'b0;
        while (busy) begin n++; tick(); end
    endtask

    task automatic peek_reg(input int r, input int exp, input string tag);
        reg_sel = r[3:0]; #1;
        chk(tag, reg_data, exp);
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 pc", pc, 0);
        chk("R13 ir", ir, 0);
        chk("R13 busy", busy, 0);
        chk("R13 halted", halted, 0);
        peek_reg(7, 0, "R13 reg");
        cmp_en = 1'b1;

        // Immediate halt image.
        clear_img(); put(0, 16'hC000); load_img();
        run_prog();
        chk("R7 halted", halted, 1);
        chk("R7 pc", pc, 8'h02);
        run = 1'b1; tick(); run = 1'b0;
        chk("R7 run ignored", busy, 0);
        tick();
        chk("R7 pc unchanged", pc, 8'h02);

        // Mixed program.
        clear_img();
        put(8'h00, 16'h217F); put(8'h02, 16'h2205); put(8'h04, 16'h5312);
        put(8'h06, 16'h6412); put(8'h08, 16'h7512); put(8'h0A, 16'h8612);
        put(8'h0C, 16'h9712); put(8'h0E, 16'h4018); put(8'h10, 16'hA103);
        put(8'h12, 16'hA209); put(8'h14, 16'h3380); put(8'h16, 16'h1980);
        put(8'h18, 16'h0123); put(8'h1A, 16'hD456); put(8'h1C, 16'hB340);
        put(8'h1E, 16'hBA30); put(8'h20, 16'h2BFF); put(8'h22, 16'hC000);
        put(8'h30, 16'h2CAA); put(8'h32, 16'hC000);
        load_img();
        run_prog();
        peek_reg(3, 8'h84, "R3 addb wraps");
        peek_reg(4, 8'h84, "R3 addf as add");
        peek_reg(5, 8'h7F, "R4 or");
        peek_reg(6, 8'h05, "R4 and");
        peek_reg(7, 8'h7A, "R4 xor");
        peek_reg(8, 8'h7F, "R2 move");
        peek_reg(1, 8'hEF, "R5 rotate 3");
        peek_reg(2, 8'h82, "R5 rotate 9 as 1");
        peek_reg(9, 8'h84, "R2 load after store");
        peek_reg(11, 8'h00, "R6 skipped write");
        peek_reg(12, 8'hAA, "R6 jump target");
        peek_reg(15, 8'h00, "R12 reserved no-op");
        ld_addr = 8'h80; #1;
        chk("R2 store", mem_data, 8'h84);
        chk("R7 halt pc", pc, 8'h34);

        // Step mode, reserved opcodes.
        clear_img();
        put(0, 16'h2A11); put(2, 16'h0F00); put(4, 16'hE123); put(6, 16'hC000);
        load_img();
        chk("R8 pc cleared", pc, 0);
        chk("R8 ir cleared", ir, 0);
        chk("R8 halted cleared", halted, 0);
        peek_reg(3, 8'h84, "R8 regs kept");
        step_one(n);
        chk("R1 three cycles", n, 3);
        chk("R1 ir bytes", ir, 16'h2A11);
        chk("R11 one insn pc", pc, 2);
        step_one(n); chk("R12 reserved 0 pc", pc, 4);
        step_one(n); chk("R12 reserved E pc", pc, 6);
        step_one(n); chk("R7 halt by step", halted, 1);
        step_one(n); chk("R7 step ignored", pc, 8);
        peek_reg(10, 8'h11, "R2 set");

        // PC wrap.
        clear_img();
        put(8'h00, 16'hBDFC); put(8'h02, 16'hC000);
        put(8'hFC, 16'h2D01); put(8'hFE, 16'h2E77);
        load_img();
        run_prog();
        peek_reg(13, 8'h01, "R9 wrap body");
        peek_reg(14, 8'h77, "R9 top cell");
        chk("R9 wrapped pc", pc, 8'h04);

        // Instruction cap.
        clear_img(); put(0, 16'hB000); load_img();
        run_prog();
        chk("R10 limit_hit", limit_hit, 1);
        chk("R10 not halted", halted, 0);
        chk("R10 pc", pc, 0);
        step_one(n);
        chk("R11 limit cleared", limit_hit, 0);
        chk("R11 step count", n, 3);

        tick();
        cmp_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule